// File: doc/BRIEF.md
# Write-Only Serial Control Slave for Backlight and Regulators

This block is a receive-only slave on a two-wire serial bus (I2C). It uses a fast system clock to oversample the bus lines and keeps the control state of a four-channel LED current driver and two linear regulators. Each update takes one write transaction of three acknowledged bytes. The first byte is the device address with the direction bit. The second byte selects a register group and carries its enable bits. The third byte carries a 5-bit level code. The block does not support reads or clock stretching. It drives the data line only to pull it low during an acknowledge.

The block stays enabled only while the chip-enable input is high. Dropping chip-enable clears every setting, so the host must write them again. A host can also force a shutdown without the enable pin. It does this by holding both bus lines low for far longer than any normal low phase. The block measures that time with a counter. When the limit is reached, the block clears its settings and asserts its shutdown output until chip-enable is cycled.

Top module: `bl_i2c_ctrl`

## Requirements
- R1: The address byte is acknowledged only when it equals 0xA8: seven address bits 1010100 followed by a 0 write bit. Any other address, and any read, leaves the data line released in the acknowledge slot.
- R2: Each accepted byte is acknowledged by pulling the data line low for the ninth clock of that byte. The pull turns on and off only while SCL is low.
- R3: A control byte whose bits 7..5 are 010 selects the LED group. Bits 3..0 become the enables of LED4..LED1, where 1 turns a channel on and bit 0 controls LED1. The low five bits of the data byte become the LED current code.
- R4: A control byte whose bits 7..5 are 001 selects a regulator. Bits 4..2 pick the regulator: 000 is regulator 1 and 001 is regulator 2. Bit 0 is that regulator's enable. The low five bits of the data byte become its voltage code.
- R5: A control byte with any other sub-address, or with a regulator target other than 000 or 001, is not acknowledged. Such a byte changes no output.
- R6: Settings change only when the acknowledge clock of the data byte completes. A STOP that arrives before then leaves every output unchanged.
- R7: While chip-enable is low, every setting output is 0, shutdown is 1 and the data line is released. After chip-enable returns, the settings stay 0 until they are written again.
- R8: If SCL and SDA are both low for LOW_CYCLES consecutive system clocks, shutdown rises and all settings clear. They stay cleared until chip-enable goes low. A shorter low phase has no effect.
- R9: After reset, with chip-enable high, all settings are 0, shutdown is 0 and the data line is released.
- R10: Bits 7..5 of the data byte have no effect on any output.
- R11: A transaction updates at most one register group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| ena | input | 1 | Chip enable, active high |
| scl | input | 1 | Bus clock line |
| sda | input | 1 | Bus data line as seen on the wire |
| sdaPullLow | output | 1 | When 1, the open-drain stage pulls SDA low |
| ledEnable | output | 4 | On/off for LED4..LED1, where bit 0 is LED1 |
| ledCode | output | 5 | LED current step |
| ldo1En | output | 1 | Regulator 1 enable |
| ldo1Code | output | 5 | Regulator 1 voltage step |
| ldo2En | output | 1 | Regulator 2 enable |
| ldo2Code | output | 5 | Regulator 2 voltage step |
| shutdown | output | 1 | 1 when the chip is disabled or the bus-low timeout has fired |

## Verification
The assertions check four things on every cycle. Settings are held at zero during shutdown or while chip-enable is low, and outputs move only on a commit strobe. The acknowledge pull changes only while SCL is low, and no commit updates two groups at once. A counter in the checker also confirms that an unbroken bus-low period of the configured length always ends in shutdown.

Some behaviour can only be shown by the bench's scenarios. These include the address match, rejection of read and of unknown sub-addresses or targets, the mapping of control bits to channels, and the disregard of the upper data bits. The scenarios also cover aborted transactions and the need to rewrite settings after chip-enable returns. The bench sweeps every LED enable pattern and every code for both regulators.

// File: rtl/bl_ctrl_pkg.sv
package bl_ctrl_pkg;
  localparam int CODE_W = 5;
  localparam int LED_N  = 4;

  localparam logic [2:0] SUB_LED  = 3'b010;
  localparam logic [2:0] SUB_LDO  = 3'b001;
  localparam logic [2:0] TGT_LDO1 = 3'b000;
  localparam logic [2:0] TGT_LDO2 = 3'b001;

  typedef enum logic [1:0] {BUS_IDLE, BUS_RX, BUS_ACK} busState_t;

  // Control-to-datapath strobes, valid for one cycle
  typedef struct packed {
    logic              commitLed;
    logic              commitLdo1;
    logic              commitLdo2;
    logic [LED_N-1:0]  ctrlBits;
    logic [CODE_W-1:0] code;
  } strobe_t;
endpackage

// File: rtl/bl_bus_ctrl.sv
module bl_bus_ctrl
  import bl_ctrl_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h54,
  parameter int         LOW_CYCLES = 125000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ena,
  input  logic    scl,
  input  logic    sda,
  output strobe_t strobe,
  output logic    sdaPullLow,
  output logic    busLowTrip,
  output logic    sclLevel
);
  localparam int LOW_W = $clog2(LOW_CYCLES + 1);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclQ, sdaQ;
  logic       sclRise, sclFall, startDet, stopDet;
  busState_t  state;
  logic [1:0] byteIdx;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg, ctrlReg;
  logic       ackOk;
  logic [LOW_W-1:0] lowCnt;

  assign sclQ     = sclSync[1];
  assign sdaQ     = sdaSync[1];
  assign sclLevel = sclQ;
  assign sclRise  = sclQ & ~sclPrev;
  assign sclFall  = ~sclQ & sclPrev;
  assign startDet = sclQ & sclPrev & sdaPrev & ~sdaQ;
  assign stopDet  = sclQ & sclPrev & ~sdaPrev & sdaQ;

  always_comb begin
    unique case (byteIdx)
      2'd0:    ackOk = (shiftReg == {SLAVE_ADDR, 1'b0});
      2'd1:    ackOk = (shiftReg[7:5] == SUB_LED) ||
                       ((shiftReg[7:5] == SUB_LDO) &&
                        ((shiftReg[4:2] == TGT_LDO1) || (shiftReg[4:2] == TGT_LDO2)));
      default: ackOk = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], scl};
      sdaSync <= {sdaSync[0], sda};
      sclPrev <= sclQ;
      sdaPrev <= sdaQ;
    end
  end

  // Bus-low timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt     <= '0;
      busLowTrip <= 1'b0;
    end else if (!ena) begin
      lowCnt     <= '0;
      busLowTrip <= 1'b0;
    end else if (!sclQ && !sdaQ) begin
      if (lowCnt != LOW_W'(LOW_CYCLES)) lowCnt <= lowCnt + 1'b1;
      else                              busLowTrip <= 1'b1;
    end else begin
      lowCnt <= '0;
    end
  end

  // Byte receiver and acknowledge sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= BUS_IDLE;
      byteIdx    <= '0;
      bitCnt     <= '0;
      shiftReg   <= '0;
      ctrlReg    <= '0;
      sdaPullLow <= 1'b0;
      strobe     <= '0;
    end else begin
      strobe <= '0;
      if (!ena || busLowTrip) begin
        state      <= BUS_IDLE;
        sdaPullLow <= 1'b0;
      end else if (startDet) begin
        state      <= BUS_RX;
        byteIdx    <= '0;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
      end else if (stopDet) begin
        state      <= BUS_IDLE;
        sdaPullLow <= 1'b0;
      end else begin
        unique case (state)
          BUS_RX: begin
            if (sclRise && bitCnt != 4'd8) begin
              shiftReg <= {shiftReg[6:0], sdaQ};
              bitCnt   <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (ackOk) begin
                sdaPullLow <= 1'b1;
                state      <= BUS_ACK;
                if (byteIdx == 2'd1) ctrlReg <= shiftReg;
              end else begin
                state <= BUS_IDLE;
              end
            end
          end
          BUS_ACK: begin
            if (sclFall) begin
              sdaPullLow <= 1'b0;
              bitCnt     <= '0;
              if (byteIdx == 2'd2) begin
                state             <= BUS_IDLE;
                strobe.commitLed  <= (ctrlReg[7:5] == SUB_LED);
                strobe.commitLdo1 <= (ctrlReg[7:5] == SUB_LDO) && (ctrlReg[4:2] == TGT_LDO1);
                strobe.commitLdo2 <= (ctrlReg[7:5] == SUB_LDO) && (ctrlReg[4:2] == TGT_LDO2);
                strobe.ctrlBits   <= ctrlReg[LED_N-1:0];
                strobe.code       <= shiftReg[CODE_W-1:0];
              end else begin
                byteIdx <= byteIdx + 1'b1;
                state   <= BUS_RX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bl_reg_path.sv
module bl_reg_path
  import bl_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  strobe_t           strobe,
  output logic [LED_N-1:0]  ledEnable,
  output logic [CODE_W-1:0] ledCode,
  output logic              ldo1En,
  output logic [CODE_W-1:0] ldo1Code,
  output logic              ldo2En,
  output logic [CODE_W-1:0] ldo2Code
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledEnable <= '0;
      ledCode   <= '0;
      ldo1En    <= 1'b0;
      ldo1Code  <= '0;
      ldo2En    <= 1'b0;
      ldo2Code  <= '0;
    end else if (clear) begin
      ledEnable <= '0;
      ledCode   <= '0;
      ldo1En    <= 1'b0;
      ldo1Code  <= '0;
      ldo2En    <= 1'b0;
      ldo2Code  <= '0;
    end else begin
      if (strobe.commitLed) begin
        ledEnable <= strobe.ctrlBits;
        ledCode   <= strobe.code;
      end
      if (strobe.commitLdo1) begin
        ldo1En   <= strobe.ctrlBits[0];
        ldo1Code <= strobe.code;
      end
      if (strobe.commitLdo2) begin
        ldo2En   <= strobe.ctrlBits[0];
        ldo2Code <= strobe.code;
      end
    end
  end
endmodule

// File: rtl/bl_i2c_ctrl.sv
module bl_i2c_ctrl
  import bl_ctrl_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h54,
  parameter int         LOW_CYCLES = 125000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ena,
  input  logic        scl,
  input  logic        sda,
  output logic        sdaPullLow,
  output logic [3:0]  ledEnable,
  output logic [4:0]  ledCode,
  output logic        ldo1En,
  output logic [4:0]  ldo1Code,
  output logic        ldo2En,
  output logic [4:0]  ldo2Code,
  output logic        shutdown
);
  strobe_t strobe;
  logic    busLowTrip;
  logic    sclLevel;

  assign shutdown = !ena || busLowTrip;

  bl_bus_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .LOW_CYCLES(LOW_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ena(ena), .scl(scl), .sda(sda),
    .strobe(strobe), .sdaPullLow(sdaPullLow), .busLowTrip(busLowTrip),
    .sclLevel(sclLevel)
  );

  bl_reg_path u_regs (
    .clk(clk), .rstN(rstN), .clear(shutdown), .strobe(strobe),
    .ledEnable(ledEnable), .ledCode(ledCode),
    .ldo1En(ldo1En), .ldo1Code(ldo1Code),
    .ldo2En(ldo2En), .ldo2Code(ldo2Code)
  );
endmodule

// File: rtl/bl_i2c_ctrl_chk.sv
module bl_i2c_ctrl_chk
  import bl_ctrl_pkg::*;
#(
  parameter int LOW_CYCLES = 125000
) (
  input logic       clk,
  input logic       rstN,
  input logic       ena,
  input logic       scl,
  input logic       sda,
  input logic       sdaPullLow,
  input logic [3:0] ledEnable,
  input logic [4:0] ledCode,
  input logic       ldo1En,
  input logic [4:0] ldo1Code,
  input logic       ldo2En,
  input logic [4:0] ldo2Code,
  input logic       shutdown,
  input strobe_t    strobe,
  input logic       sclLevel
);
  int unsigned rawLowCnt;
  logic        allClear;

  assign allClear = (ledEnable == '0) && (ledCode == '0) && !ldo1En && (ldo1Code == '0)
                 && !ldo2En && (ldo2Code == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rawLowCnt <= 0;
    else if (!ena)            rawLowCnt <= 0;
    else if (!scl && !sda) begin
      if (rawLowCnt < LOW_CYCLES + 8) rawLowCnt <= rawLowCnt + 1;
    end else                  rawLowCnt <= 0;
  end

  AST_ENA_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !ena |=> allClear); // R7
  AST_NO_PULL_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !ena |=> !sdaPullLow); // R7
  AST_SHUTDOWN_HOLDS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |=> allClear); // R8
  AST_BUS_LOW_TRIPS: assert property (@(posedge clk) disable iff (!rstN || !ena)
    (rawLowCnt >= LOW_CYCLES + 4) |-> shutdown); // R8
  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN || !ena)
    ($past(ena) && (sdaPullLow != $past(sdaPullLow))) |-> !sclLevel); // R2
  AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.commitLed, strobe.commitLdo1, strobe.commitLdo2})); // R11
  AST_LED_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(shutdown) && !$past(strobe.commitLed)) |-> ($stable(ledEnable) && $stable(ledCode))); // R6
  AST_LDO_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(shutdown) && !$past(strobe.commitLdo1) && !$past(strobe.commitLdo2))
      |-> ($stable(ldo1Code) && $stable(ldo2Code) && $stable(ldo1En) && $stable(ldo2En))); // R6
endmodule

bind bl_i2c_ctrl bl_i2c_ctrl_chk #(.LOW_CYCLES(LOW_CYCLES)) chk (.*);

// File: tb/tb_bl_i2c_ctrl.sv
module tb_bl_i2c_ctrl;
  localparam int LOWC = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ena = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaLine;
  logic sdaPullLow, ldo1En, ldo2En, shutdown;
  logic [3:0] ledEnable;
  logic [4:0] ledCode, ldo1Code, ldo2Code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] expLed;
  logic [4:0] expLedCode, expL1Code, expL2Code;
  logic       expL1En, expL2En;

  always #4 clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaPullLow;

  bl_i2c_ctrl #(.LOW_CYCLES(LOWC)) dut (
    .clk(clk), .rstN(rstN), .ena(ena), .scl(sclDrv), .sda(sdaLine),
    .sdaPullLow(sdaPullLow), .ledEnable(ledEnable), .ledCode(ledCode),
    .ldo1En(ldo1En), .ldo1Code(ldo1Code), .ldo2En(ldo2En), .ldo2Code(ldo2Code),
    .shutdown(shutdown)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic checkRegs(input string req);
    checkVal(req, "ledEnable", ledEnable, expLed);
    checkVal(req, "ledCode", ledCode, expLedCode);
    checkVal(req, "ldo1En", ldo1En, expL1En);
    checkVal(req, "ldo1Code", ldo1Code, expL1Code);
    checkVal(req, "ldo2En", ldo2En, expL2En);
    checkVal(req, "ldo2Code", ldo2Code, expL2Code);
  endtask

  task automatic clearModel();
    expLed = '0; expLedCode = '0; expL1En = 0; expL1Code = '0; expL2En = 0; expL2Code = '0;
  endtask

  task automatic busStart();
    sdaDrv = 1; sclDrv = 1; waitN(8);
    sdaDrv = 0; waitN(8);
  endtask

  task automatic busStop();
    sclDrv = 0; waitN(2); sdaDrv = 0; waitN(6);
    sclDrv = 1; waitN(8);
    sdaDrv = 1; waitN(8);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sclDrv = 0; waitN(2); sdaDrv = b[i]; waitN(6);
      sclDrv = 1; waitN(8);
    end
    sclDrv = 0; waitN(2); sdaDrv = 1; waitN(6);
    ack = ~sdaLine;
    sclDrv = 1; waitN(8);
    sclDrv = 0; waitN(8);
  endtask

  // Full or partial write; nBytes limits how many bytes are sent before STOP
  task automatic writeTxn(input string req, input logic [7:0] addr, input logic [7:0] ctrl,
                          input logic [7:0] data, input int nBytes);
    logic a0, a1, a2;
    logic e0, e1;
    e0 = (addr == 8'hA8);
    e1 = (ctrl[7:5] == 3'b010) || ((ctrl[7:5] == 3'b001) && (ctrl[4:2] <= 3'b001));
    busStart();
    sendByte(addr, a0);
    checkVal(req, "addr ack", a0, e0);
    if (a0 && nBytes > 1) begin
      sendByte(ctrl, a1);
      checkVal(req, "ctrl ack", a1, e1);
      if (a1 && nBytes > 2) begin
        sendByte(data, a2);
        checkVal(req, "data ack", a2, 1);
        if (ctrl[7:5] == 3'b010) begin
          expLed = ctrl[3:0]; expLedCode = data[4:0];
        end else if (ctrl[4:2] == 3'b000) begin
          expL1En = ctrl[0]; expL1Code = data[4:0];
        end else begin
          expL2En = ctrl[0]; expL2Code = data[4:0];
        end
      end
    end
    busStop();
    checkVal("R2", "released after txn", sdaPullLow, 0);
    checkRegs(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clearModel();
    waitN(4);
    ena = 1;
    rstN = 1;
    waitN(6);
    // R9 reset state
    checkRegs("R9");
    checkVal("R9", "shutdown", shutdown, 0);
    checkVal("R9", "sdaPullLow", sdaPullLow, 0);

    // R3 all LED enable patterns, R10 noise in data bits 7..5
    for (int en = 0; en < 16; en++) begin
      logic [7:0] d;
      d = {3'(en), 5'((en * 7 + 3) % 32)};
      writeTxn("R3", 8'hA8, {3'b010, 1'b0, 4'(en)}, d, 3);
    end
    checkVal("R10", "ledCode low bits only", ledCode, ((15 * 7 + 3) % 32));

    // R4 every code on both regulators
    for (int c = 0; c < 32; c++) begin
      writeTxn("R4", 8'hA8, {3'b001, 3'b000, 1'b0, 1'(c)}, {3'b111, 5'(c)}, 3);
      writeTxn("R4", 8'hA8, {3'b001, 3'b001, 1'b0, ~1'(c)}, {3'b000, 5'(31 - c)}, 3);
    end

    // R1 wrong address and read direction
    writeTxn("R1", 8'hAA, 8'h4F, 8'h1F, 3);
    writeTxn("R1", 8'hA9, 8'h4F, 8'h1F, 3);
    writeTxn("R1", 8'h54, 8'h4F, 8'h1F, 3);

    // R5 unknown sub-address and target
    writeTxn("R5", 8'hA8, 8'h6F, 8'h11, 3);
    writeTxn("R5", 8'hA8, 8'h0F, 8'h11, 3);
    writeTxn("R5", 8'hA8, {3'b001, 3'b010, 2'b01}, 8'h11, 3);

    // R6 aborted transactions
    writeTxn("R6", 8'hA8, 8'h45, 8'h09, 2);
    writeTxn("R6", 8'hA8, 8'h25, 8'h09, 1);
    writeTxn("R6", 8'hA8, 8'h45, 8'h09, 3);

    // R7 chip enable drop
    ena = 0; waitN(10);
    clearModel();
    checkVal("R7", "shutdown while disabled", shutdown, 1);
    checkVal("R7", "sdaPullLow while disabled", sdaPullLow, 0);
    checkRegs("R7");
    ena = 1; waitN(10);
    checkVal("R7", "shutdown after enable", shutdown, 0);
    checkRegs("R7");
    writeTxn("R7", 8'hA8, 8'h4A, 8'h13, 3);

    // R8 short bus-low has no effect
    sclDrv = 0; waitN(2); sdaDrv = 0; waitN(LOWC - 50);
    sdaDrv = 1; waitN(2); sclDrv = 1; waitN(10);
    checkVal("R8", "no trip on short low", shutdown, 0);
    checkRegs("R8");
    // R8 long bus-low forces shutdown
    sclDrv = 0; waitN(2); sdaDrv = 0; waitN(LOWC + 20);
    clearModel();
    checkVal("R8", "trip on long low", shutdown, 1);
    checkRegs("R8");
    sdaDrv = 1; waitN(2); sclDrv = 1; waitN(10);
    checkVal("R8", "trip held after release", shutdown, 1);
    ena = 0; waitN(4); ena = 1; waitN(6);
    checkVal("R8", "recovered after enable cycle", shutdown, 0);
    writeTxn("R8", 8'hA8, 8'h25, 8'h1E, 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule